// File: doc/BRIEF.md
# I2C Register-Port Target

This block is the bus-facing front end of a small register-mapped port peripheral. It takes the raw SCL and SDA lines, brings them into the system clock domain, and finds START and STOP conditions. It then runs the target side of the I2C protocol. The 7-bit target address is partly fixed and partly set by two strap inputs. The block acknowledges its own address and then moves bytes between the bus and four 8-bit registers.

The first byte after a write address is a command byte. It is loaded into a pointer that software cannot read back. Every later byte of that write goes into the register the pointer selects. A read address returns the selected register, repeated for as long as the master keeps acknowledging. The pointer does not advance, so a burst always touches one register. Code 00h reads a live input word. Codes 01h to 03h select three writable registers. All other codes are acknowledged and have no effect.

SDA is controlled only through an open-drain pull-low enable. A level-sensitive active-low reset holds the protocol engine and all registers at their defaults for as long as it stays low.

Top module: `i2c_port_target`

## Requirements
- R1: After reset the output register reads FFh, the polarity register 00h and the configuration register FFh. The pointer is 00h and SDA is released (sda_oe low).
- R2: The target address is binary 11100 followed by strap[1] and strap[0]. The eighth address bit is the direction, 1 for read. Only a matching address is acknowledged by pulling SDA low in the ninth clock. After a mismatch the block leaves SDA alone until the next START.
- R3: In a write, the first byte after the address loads the pointer. Each following byte is stored in the selected register: code 01h is the output register, 02h the polarity register and 03h the configuration register. Every byte is acknowledged.
- R4: In a read, each byte returns the selected register, MSB first. Code 00h returns in_port. SDA changes only while SCL is low.
- R5: A data byte written with the pointer at 00h changes no register, because the input word is read-only.
- R6: The pointer never advances. Consecutive data bytes in one write all go to the same register, and consecutive bytes in one read all return it. The read continues while the master acknowledges, and a master NACK ends it with SDA released.
- R7: Pointer codes above 03h are acknowledged as command and data bytes, but writes to them change nothing and reads of them return 00h.
- R8: While rst_n is low the engine gives no acknowledge and every register stays at its R1 default. This holds even if rst_n falls in the middle of a transfer.
- R9: A repeated START begins a new address phase. The pointer keeps its value across repeated STARTs and across STOPs, so a read without a command byte returns the register last selected.
- R10: While the engine is idle, sda_oe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low level reset; holds engine and registers at defaults |
| strap | input | 2 | Low two bits of the target address |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when high |
| in_port | input | 8 | Input word returned for pointer code 00h |
| out_q | output | 8 | Output register (code 01h) |
| pol_q | output | 8 | Polarity register (code 02h) |
| cfg_q | output | 8 | Configuration register (code 03h) |

## Verification
The bench sweeps 24 addresses against every strap setting. An engine that decodes the fixed bits or the straps wrongly would acknowledge a neighbouring address or miss its own. It writes to code 00h and to codes above 03h and then reads all three registers back. A design that let those codes through would corrupt a register or return stale data instead of 00h. Multi-byte bursts in both directions check the fixed pointer: an auto-incrementing design would spread the bytes across registers. Reset is applied in the middle of a byte to catch an engine that keeps driving SDA or keeps its registers while reset is held.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;
   localparam int BYTE_W = 8;
   localparam int NREG   = 4;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
      ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
   } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_d, sda_d;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_ff[0] <= 1'b1;
         sda_ff[0] <= 1'b1;
      end else begin
         scl_ff[0] <= scl_i;
         sda_ff[0] <= sda_i;
      end
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scl_ff[i] <= 1'b1;
            sda_ff[i] <= 1'b1;
         end else begin
            scl_ff[i] <= scl_ff[i-1];
            sda_ff[i] <= sda_ff[i-1];
         end
      end
   end

   assign scl_s = scl_ff[STAGES-1];
   assign sda_s = sda_ff[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_port_pkg::*;
#(
   parameter byte_t OUT_RST = 8'hFF,
   parameter byte_t POL_RST = 8'h00,
   parameter byte_t CFG_RST = 8'hFF
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  byte_t wr_ptr,
   input  byte_t wr_data,
   input  byte_t rd_ptr,
   input  byte_t in_port,
   output byte_t rd_data,
   output byte_t out_q,
   output byte_t pol_q,
   output byte_t cfg_q
);
   localparam logic [3*BYTE_W-1:0] RST_VEC = {CFG_RST, POL_RST, OUT_RST};

   byte_t regs [NREG-1:1];

   for (genvar i = 1; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= RST_VEC[(i-1)*BYTE_W +: BYTE_W];
         else if (wr_en && wr_ptr == BYTE_W'(i))
            regs[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_ptr == '0)
         rd_data = in_port;
      for (int k = 1; k < NREG; k++)
         if (rd_ptr == BYTE_W'(k))
            rd_data = regs[k];
   end

   assign out_q = regs[1];
   assign pol_q = regs[2];
   assign cfg_q = regs[3];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_port_pkg::*;
#(
   parameter int FIXED_W = 5,
   parameter int STRAP_W = 2,
   parameter logic [FIXED_W-1:0] ADDR_FIXED = 5'b11100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  byte_t              rd_data,
   output logic               sda_oe,
   output logic               wr_en,
   output byte_t              wr_data,
   output byte_t              ptr,
   output logic               idle
);
   localparam int ADDR_W = FIXED_W + STRAP_W;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
      $error("i2c_tgt_fsm: address plus direction bit must fill one byte");
   end

   bus_st_e          state;
   byte_t            shreg;
   logic [CNT_W-1:0] cnt;
   logic             rw, acked;
   logic [ADDR_W-1:0] my_addr;

   assign my_addr = {ADDR_FIXED, strap};
   assign idle    = (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         shreg   <= '0;
         cnt     <= '0;
         rw      <= 1'b0;
         acked   <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         ptr     <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_WDAT: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + CNT_W'(1);
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[BYTE_W-1:1] == my_addr) begin
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_CMD) begin
                        ptr    <= shreg;
                        sda_oe <= 1'b1;
                        state  <= ST_CMD_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_data <= shreg;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDAT_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK, ST_WDAT_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDAT;
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (cnt == CNT_LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~shreg[BYTE_W-2];
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        cnt    <= cnt + CNT_W'(1);
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     acked <= ~sda_s;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (acked) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_RDAT;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_port_target.sv
module i2c_port_target
   import i2c_port_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FIXED_W     = 5,
   parameter int STRAP_W     = 2,
   parameter logic [FIXED_W-1:0] ADDR_FIXED = 5'b11100,
   parameter byte_t OUT_RST  = 8'hFF,
   parameter byte_t POL_RST  = 8'h00,
   parameter byte_t CFG_RST  = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [7:0]         in_port,
   output logic [7:0]         out_q,
   output logic [7:0]         pol_q,
   output logic [7:0]         cfg_q
);
   if (FIXED_W + STRAP_W != 7) begin : g_bad_width
      $error("i2c_port_target: fixed and strap bits must total seven");
   end

   logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic  wr_en, fsm_idle;
   byte_t wr_data, ptr, rd_data;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_tgt_fsm #(.FIXED_W(FIXED_W), .STRAP_W(STRAP_W), .ADDR_FIXED(ADDR_FIXED)) u_fsm (
      .clk(clk), .rst_n(rst_n), .strap(strap), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data),
      .ptr(ptr), .idle(fsm_idle)
   );

   i2c_reg_bank #(.OUT_RST(OUT_RST), .POL_RST(POL_RST), .CFG_RST(CFG_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr), .wr_data(wr_data),
      .rd_ptr(ptr), .in_port(in_port), .rd_data(rd_data),
      .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
   );
endmodule

// File: rtl/i2c_port_target_chk.sv
module i2c_port_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic       fsm_idle,
   input logic [7:0] out_q,
   input logic [7:0] pol_q,
   input logic [7:0] cfg_q
);
   // R1 and R8: registers leave reset at their defaults with SDA released
   p_reset_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_q == 8'hFF && pol_q == 8'h00 && cfg_q == 8'hFF && !sda_oe));

   // R4: the target starts pulling SDA only while SCL is low
   p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R10: no drive while the engine is idle
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_idle |-> !sda_oe);

   // R3: register updates land while SCL is low
   p_write_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({out_q, pol_q, cfg_q}) |-> !scl_s);
endmodule

bind i2c_port_target i2c_port_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .fsm_idle(fsm_idle),
   .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
);

// File: tb/i2c_port_target_test.sv
module i2c_port_target_test;
   localparam int Q = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic [1:0] strap;
   logic       scl_m, sda_m;
   logic [7:0] in_port;
   wire        sda_oe;
   wire [7:0]  out_q, pol_q, cfg_q;
   wire        sda_line = sda_m & ~sda_oe;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] e_out, e_pol, e_cfg;

   i2c_port_target uut (
      .clk(clk), .rst_n(rst_n), .strap(strap), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .in_port(in_port), .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      chk(req, out_q, e_out);
      chk(req, pol_q, e_pol);
      chk(req, cfg_q, e_cfg);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic wbit(input logic b);
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(output logic [7:0] d, input logic mack);
      for (int i = 7; i >= 0; i--) rbit(d[i]);
      wbit(~mack);
   endtask

   task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                         output logic [2:0] acks);
      bus_start;
      wbyte({a, 1'b0}, acks[2]);
      wbyte(p, acks[1]);
      wbyte(d, acks[0]);
      bus_stop;
   endtask

   task automatic rd_reg(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
      logic k;
      bus_start;
      wbyte({a, 1'b0}, k);
      wbyte(p, k);
      bus_start;
      wbyte({a, 1'b1}, k);
      rbyte(d, 1'b0);
      bus_stop;
   endtask

   initial begin
      tick(190000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [6:0] me;
      logic [2:0] acks;
      logic [7:0] d;
      logic       k;

      rst_n = 1'b0; strap = 2'd0; scl_m = 1'b1; sda_m = 1'b1; in_port = 8'hC6;
      e_out = 8'hFF; e_pol = 8'h00; e_cfg = 8'hFF;
      tick(10);
      rst_n = 1'b1;
      tick(5);
      // R1: reset state
      chk_regs("R1");
      chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);

      // R2: address sweep over every strap value
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         tick(4);
         for (int a = 8'h68; a < 8'h80; a++) begin
            bus_start;
            wbyte({7'(a), 1'b0}, k);
            bus_stop;
            chk("R2 ack", {7'd0, k}, {7'd0, (7'(a) == {5'b11100, 2'(s)})});
         end
      end
      strap = 2'd2;
      me = 7'h72;
      tick(4);

      // R3/R4: write then read back each writable register
      for (int p = 1; p < 4; p++) begin
         d = 8'h5A ^ 8'(p * 37);
         wr_reg(me, 8'(p), d, acks);
         chk("R3 acks", {5'd0, acks}, 8'h07);
         if (p == 1) e_out = d;
         if (p == 2) e_pol = d;
         if (p == 3) e_cfg = d;
         chk_regs("R3");
         rd_reg(me, 8'(p), d);
         chk("R4 readback", d, 8'h5A ^ 8'(p * 37));
      end
      // R4: MSB-first with single-bit patterns
      wr_reg(me, 8'h01, 8'h80, acks); e_out = 8'h80;
      rd_reg(me, 8'h01, d); chk("R4 msb", d, 8'h80);
      wr_reg(me, 8'h01, 8'h01, acks); e_out = 8'h01;
      rd_reg(me, 8'h01, d); chk("R4 lsb", d, 8'h01);
      // R4: code 00h reads in_port
      rd_reg(me, 8'h00, d); chk("R4 input", d, 8'hC6);
      in_port = 8'h39;
      rd_reg(me, 8'h00, d); chk("R4 input", d, 8'h39);

      // R5: writing through code 00h changes nothing
      wr_reg(me, 8'h00, 8'h33, acks);
      chk("R5 acks", {5'd0, acks}, 8'h07);
      chk_regs("R5");
      rd_reg(me, 8'h00, d); chk("R5 input", d, 8'h39);

      // R7: codes above 03h acknowledged, ignored, read 00h
      for (int p = 4; p < 256; p += 123) begin
         wr_reg(me, 8'(p), 8'hA5, acks);
         chk("R7 acks", {5'd0, acks}, 8'h07);
         chk_regs("R7");
         rd_reg(me, 8'(p), d);
         chk("R7 read", d, 8'h00);
      end

      // R6: burst write stays on one register
      bus_start;
      wbyte({me, 1'b0}, k);
      wbyte(8'h02, k);
      wbyte(8'h11, k);
      wbyte(8'h22, k);
      wbyte(8'h44, k);
      chk("R6 burst ack", {7'd0, k}, 8'h01);
      bus_stop;
      e_pol = 8'h44;
      chk_regs("R6");

      // R6/R9: select code 03h, repeated START into a three-byte read
      bus_start;
      wbyte({me, 1'b0}, k);
      wbyte(8'h03, k);
      bus_start;
      wbyte({me, 1'b1}, k);
      for (int i = 0; i < 3; i++) begin
         rbyte(d, i < 2);
         chk("R6 burst read", d, e_cfg);
      end
      tick(4);
      chk("R6 released", {7'd0, sda_oe}, 8'h00);
      bus_stop;

      // R9: a read with no command byte uses the retained pointer
      bus_start;
      wbyte({me, 1'b1}, k);
      rbyte(d, 1'b0);
      bus_stop;
      chk("R9 pointer kept", d, e_cfg);

      // R8: reset in the middle of a byte
      bus_start;
      wbyte({me, 1'b0}, k);
      wbyte(8'h01, k);
      wbit(1'b0); wbit(1'b1); wbit(1'b0);
      rst_n = 1'b0;
      tick(3);
      e_out = 8'hFF; e_pol = 8'h00; e_cfg = 8'hFF;
      chk_regs("R8 mid");
      chk("R8 oe", {7'd0, sda_oe}, 8'h00);
      bus_stop;
      wr_reg(me, 8'h02, 8'h5C, acks);
      chk("R8 no ack", {5'd0, acks}, 8'h00);
      chk_regs("R8 held");
      rst_n = 1'b1;
      tick(5);
      chk_regs("R8 after");
      // R1: pointer defaults to 00h
      bus_start;
      wbyte({me, 1'b1}, k);
      rbyte(d, 1'b0);
      bus_stop;
      chk("R1 pointer", d, 8'h39);
      // R10: idle after all traffic
      tick(4);
      chk("R10 idle", {7'd0, sda_oe}, 8'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule